// File: doc/BRIEF.md
# Pad Configuration Register Bank

This block is the software-visible control store for one bank of up to 32 pads. A processor reaches it through a plain 32-bit register bus with write and read strobes. Each pad has its own function-select register. The bank also has four one-bit-per-pad vectors (pull-up, pull-down, slew, open-drain) and a drive-strength field of two bits per pad. The drive fields are packed sixteen pads to a word, across two words. Every stored value is driven continuously to the pad ring as per-pad control outputs. A function-select value of 0 puts a pad in plain GPIO mode.

The set of pads that physically exist is fixed when the bank is built, by a parameter bitmap. Software can read that bitmap from a read-only register. A pad that is missing, or that lies at or beyond `PAD_COUNT`, accepts no configuration. Its fields stay 0 and read back as 0. A bank occupies a 0x100-byte window, so several banks can be placed side by side by an outer decoder.

The bus side is run by a two-state machine. `ST_IDLE` means no read data is pending. `ST_RESP` means the word captured by the previous read is being presented. The transition `IDLE_TO_RESP` and the self-loop `RESP_HOLD` are taken whenever `bus_rd` is high at a clock edge. `RESP_TO_IDLE` and the self-loop `IDLE_HOLD` are taken when it is low.

Top module: `pad_cfg_bank`

## Requirements
- R1: While `rst_n` is low, and right after it rises, every function select, pull-up, pull-down, slew, open-drain and drive output is 0, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: A write to byte offset 4·n, where n < `PAD_COUNT` and pad n is available, stores the low `FSEL_W` bits of the write data as pad n's function select. The value appears on `pad_func[n*FSEL_W +: FSEL_W]` after that clock edge, and a read of the same offset returns it zero-extended.
- R3: Offset 0x80 holds pull-up enable and offset 0x84 holds pull-down enable. In both, bit n belongs to pad n and drives `pad_pu[n]` or `pad_pd[n]` respectively.
- R4: Offset 0x88 holds slew control and offset 0x94 holds open-drain enable. In both, bit n belongs to pad n and drives `pad_slew[n]` or `pad_od[n]` respectively.
- R5: Drive strength for pad n lives in the word at 0x8C when n < 16 and in the word at 0x90 otherwise, at bits [2·(n%16)+1 : 2·(n%16)]. It drives `pad_drv[2n+1:2n]`.
- R6: Offset 0x98 reads the availability bitmap. Bit n is 1 exactly when pad n is below `PAD_COUNT` and `AVAIL[n]` is 1. Writes to this offset change nothing.
- R7: Writes never change any field of an unavailable pad: its function select, its bit in each vector and its drive field stay 0 and read back as 0.
- R8: An offset whose two low bits are not 00, a function-select slot at or beyond `PAD_COUNT`, and the offsets 0x9C to 0xFF read as 0, and writes to them change nothing.
- R9: A read strobe sampled at a clock edge puts the addressed word on `bus_rdata` with `bus_rvalid` high for the next cycle. A read issued in the same cycle as a write returns the contents from before that write.
- R10: In a cycle without `bus_wr`, no pad output changes at the following edge. A write takes effect at the edge that samples it.
- R11: The bus state machine moves `ST_IDLE` to `ST_RESP` on a read strobe, and stays in `ST_RESP` while back-to-back reads continue. It returns to `ST_IDLE` when the strobe is low. `bus_rvalid` is high exactly in `ST_RESP`, and `bus_rdata` is 0 in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe, one word per cycle |
| bus_addr | input | 8 | Byte offset inside the bank window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| pad_func | output | PAD_COUNT*FSEL_W | Function select per pad, pad n at [n*FSEL_W +: FSEL_W] |
| pad_pu | output | PAD_COUNT | Pull-up enable per pad |
| pad_pd | output | PAD_COUNT | Pull-down enable per pad |
| pad_slew | output | PAD_COUNT | Slew control per pad |
| pad_od | output | PAD_COUNT | Open-drain enable per pad |
| pad_drv | output | 2*PAD_COUNT | Drive strength per pad, pad n at [2n+1:2n] |

## Verification
The bench builds the bank with `PAD_COUNT` = 24, `FSEL_W` = 3 and an `AVAIL` bitmap with holes at pads 1, 3 and 21 and with bits set above pad 23. With these values, one run reaches the following cases:
- function-select slots past the last pad, which must read as 0;
- a second drive word that is only half populated;
- availability bits that must be masked off because they name pads the bank does not have;
- write data wider than the select field, which must be truncated.

A behavioural model updates on every edge, and every pad output and every read word is compared against it. A pseudo-random sweep of aligned, misaligned and out-of-window offsets is then run. The bench also issues a read and a write in the same cycle, back-to-back reads, and a reset in the middle of the run.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;

    localparam int BUS_W        = 32;
    localparam int ADDR_W       = 8;
    localparam int MAX_PADS     = 32;
    localparam int DRV_W        = 2;
    localparam int PADS_PER_DRV = BUS_W / DRV_W;

    localparam logic [ADDR_W-1:0] OFS_PULLUP = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_PULLDN = 8'h84;
    localparam logic [ADDR_W-1:0] OFS_SLEW   = 8'h88;
    localparam logic [ADDR_W-1:0] OFS_DRV_LO = 8'h8C;
    localparam logic [ADDR_W-1:0] OFS_DRV_HI = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_OPENDR = 8'h94;
    localparam logic [ADDR_W-1:0] OFS_AVAIL  = 8'h98;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_FUNC,
        SEL_PULLUP,
        SEL_PULLDN,
        SEL_SLEW,
        SEL_DRV_LO,
        SEL_DRV_HI,
        SEL_OPENDR,
        SEL_AVAIL
    } reg_sel_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_t;

    typedef struct packed {
        logic             pu;
        logic             pd;
        logic             slew;
        logic             od;
        logic [DRV_W-1:0] drv;
    } pad_ctl_t;

    // Pads that exist: inside the bank size and flagged in the bitmap.
    function automatic logic [BUS_W-1:0] usable_mask(input int pads,
                                                     input logic [BUS_W-1:0] avail);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_PADS; i++) begin
            m[i] = (i < pads) && avail[i];
        end
        return m;
    endfunction

endpackage

// File: rtl/pad_addr_decode.sv
module pad_addr_decode
    import pad_cfg_pkg::*;
#(
    parameter int PAD_COUNT = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel,
    output logic [4:0]        pad_idx
);

    localparam logic [5:0] FUNC_LIMIT = 6'(PAD_COUNT);

    always_comb begin
        sel     = SEL_NONE;
        pad_idx = addr[6:2];
        if (addr[1:0] == 2'b00) begin
            if (!addr[7]) begin
                if ({1'b0, addr[6:2]} < FUNC_LIMIT) begin
                    sel = SEL_FUNC;
                end
            end else begin
                case (addr)
                    OFS_PULLUP: sel = SEL_PULLUP;
                    OFS_PULLDN: sel = SEL_PULLDN;
                    OFS_SLEW:   sel = SEL_SLEW;
                    OFS_DRV_LO: sel = SEL_DRV_LO;
                    OFS_DRV_HI: sel = SEL_DRV_HI;
                    OFS_OPENDR: sel = SEL_OPENDR;
                    OFS_AVAIL:  sel = SEL_AVAIL;
                    default:    sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/pad_slot.sv
module pad_slot
    import pad_cfg_pkg::*;
#(
    parameter int FSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_func,
    input  logic [FSEL_W-1:0] func_d,
    input  logic              we_pu,
    input  logic              we_pd,
    input  logic              we_slew,
    input  logic              we_od,
    input  logic              we_drv,
    input  logic              bit_d,
    input  logic [DRV_W-1:0]  drv_d,
    output logic [FSEL_W-1:0] func_q,
    output pad_ctl_t          ctl_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_q <= '0;
        end else if (we_func) begin
            func_q <= func_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (we_pu)   ctl_q.pu   <= bit_d;
            if (we_pd)   ctl_q.pd   <= bit_d;
            if (we_slew) ctl_q.slew <= bit_d;
            if (we_od)   ctl_q.od   <= bit_d;
            if (we_drv)  ctl_q.drv  <= drv_d;
        end
    end

endmodule

// File: rtl/pad_bus_ctrl.sv
module pad_bus_ctrl
    import pad_cfg_pkg::*;
#(
    parameter int               PAD_COUNT = 32,
    parameter int               FSEL_W    = 4,
    parameter logic [BUS_W-1:0] USABLE    = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_rd,
    input  reg_sel_t                    sel,
    input  logic [4:0]                  pad_idx,
    input  logic [PAD_COUNT*FSEL_W-1:0] func_flat,
    input  logic [PAD_COUNT-1:0]        pu,
    input  logic [PAD_COUNT-1:0]        pd,
    input  logic [PAD_COUNT-1:0]        slew,
    input  logic [PAD_COUNT-1:0]        od,
    input  logic [DRV_W*PAD_COUNT-1:0]  drv_flat,
    output logic [BUS_W-1:0]            rdata,
    output logic                        rvalid
);

    bus_state_t       state_q, state_d;
    logic [BUS_W-1:0] read_word;
    logic [BUS_W-1:0] rdata_q;

    // Word selected by the decoded offset.
    always_comb begin
        read_word = '0;
        case (sel)
            SEL_FUNC:   read_word[FSEL_W-1:0] = func_flat[pad_idx*FSEL_W +: FSEL_W];
            SEL_PULLUP: for (int i = 0; i < PAD_COUNT; i++) read_word[i] = pu[i];
            SEL_PULLDN: for (int i = 0; i < PAD_COUNT; i++) read_word[i] = pd[i];
            SEL_SLEW:   for (int i = 0; i < PAD_COUNT; i++) read_word[i] = slew[i];
            SEL_OPENDR: for (int i = 0; i < PAD_COUNT; i++) read_word[i] = od[i];
            SEL_DRV_LO: begin
                for (int i = 0; i < PAD_COUNT; i++) begin
                    if (i < PADS_PER_DRV) read_word[DRV_W*i +: DRV_W] = drv_flat[DRV_W*i +: DRV_W];
                end
            end
            SEL_DRV_HI: begin
                for (int i = 0; i < PAD_COUNT; i++) begin
                    if (i >= PADS_PER_DRV)
                        read_word[DRV_W*(i-PADS_PER_DRV) +: DRV_W] = drv_flat[DRV_W*i +: DRV_W];
                end
            end
            SEL_AVAIL:  read_word = USABLE;
            default:    read_word = '0;
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = bus_rd ? ST_RESP : ST_IDLE;  // IDLE_TO_RESP / IDLE_HOLD
            ST_RESP: state_d = bus_rd ? ST_RESP : ST_IDLE;  // RESP_HOLD / RESP_TO_IDLE
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: capture on read, clear otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= bus_rd ? read_word : '0;
        end
    end

    assign rdata  = rdata_q;
    assign rvalid = (state_q == ST_RESP);

endmodule

// File: rtl/pad_cfg_bank.sv
module pad_cfg_bank
    import pad_cfg_pkg::*;
#(
    parameter int               PAD_COUNT = 32,
    parameter int               FSEL_W    = 4,
    parameter logic [BUS_W-1:0] AVAIL     = 32'hFFFF_FFFF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [7:0]                  bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic                        bus_rvalid,
    output logic [PAD_COUNT*FSEL_W-1:0] pad_func,
    output logic [PAD_COUNT-1:0]        pad_pu,
    output logic [PAD_COUNT-1:0]        pad_pd,
    output logic [PAD_COUNT-1:0]        pad_slew,
    output logic [PAD_COUNT-1:0]        pad_od,
    output logic [2*PAD_COUNT-1:0]      pad_drv
);

    localparam logic [BUS_W-1:0] USABLE = usable_mask(PAD_COUNT, AVAIL);

    reg_sel_t   sel;
    logic [4:0] pad_idx;

    pad_addr_decode #(.PAD_COUNT(PAD_COUNT)) u_decode (
        .addr    (bus_addr),
        .sel     (sel),
        .pad_idx (pad_idx)
    );

    for (genvar i = 0; i < PAD_COUNT; i++) begin : g_pad
        localparam logic     LIVE    = USABLE[i];
        localparam logic [4:0] IDX   = 5'(i);
        localparam reg_sel_t DRV_SEL = (i < PADS_PER_DRV) ? SEL_DRV_LO : SEL_DRV_HI;
        localparam int       DRV_LSB = DRV_W * (i % PADS_PER_DRV);

        logic     wr_live;
        pad_ctl_t ctl;

        assign wr_live = bus_wr && LIVE;

        pad_slot #(.FSEL_W(FSEL_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_func (wr_live && (sel == SEL_FUNC) && (pad_idx == IDX)),
            .func_d  (bus_wdata[FSEL_W-1:0]),
            .we_pu   (wr_live && (sel == SEL_PULLUP)),
            .we_pd   (wr_live && (sel == SEL_PULLDN)),
            .we_slew (wr_live && (sel == SEL_SLEW)),
            .we_od   (wr_live && (sel == SEL_OPENDR)),
            .we_drv  (wr_live && (sel == DRV_SEL)),
            .bit_d   (bus_wdata[i]),
            .drv_d   (bus_wdata[DRV_LSB +: DRV_W]),
            .func_q  (pad_func[i*FSEL_W +: FSEL_W]),
            .ctl_q   (ctl)
        );

        assign pad_pu[i]             = ctl.pu;
        assign pad_pd[i]             = ctl.pd;
        assign pad_slew[i]           = ctl.slew;
        assign pad_od[i]             = ctl.od;
        assign pad_drv[2*i +: DRV_W] = ctl.drv;
    end

    pad_bus_ctrl #(
        .PAD_COUNT (PAD_COUNT),
        .FSEL_W    (FSEL_W),
        .USABLE    (USABLE)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .sel       (sel),
        .pad_idx   (pad_idx),
        .func_flat (pad_func),
        .pu        (pad_pu),
        .pd        (pad_pd),
        .slew      (pad_slew),
        .od        (pad_od),
        .drv_flat  (pad_drv),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

endmodule

// File: rtl/pad_cfg_bank_chk.sv
module pad_cfg_bank_chk #(
    parameter int          PAD_COUNT = 32,
    parameter int          FSEL_W    = 4,
    parameter logic [31:0] AVAIL     = 32'hFFFF_FFFF
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [7:0]                  bus_addr,
    input logic [31:0]                 bus_wdata,
    input logic [31:0]                 bus_rdata,
    input logic                        bus_rvalid,
    input logic [PAD_COUNT*FSEL_W-1:0] pad_func,
    input logic [PAD_COUNT-1:0]        pad_pu,
    input logic [PAD_COUNT-1:0]        pad_pd,
    input logic [PAD_COUNT-1:0]        pad_slew,
    input logic [PAD_COUNT-1:0]        pad_od,
    input logic [2*PAD_COUNT-1:0]      pad_drv
);

    function automatic logic [31:0] present_pads();
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < PAD_COUNT; i++) m[i] = AVAIL[i];
        return m;
    endfunction

    localparam logic [31:0]          PRESENT   = present_pads();
    localparam logic [PAD_COUNT-1:0] PRESENT_P = PRESENT[PAD_COUNT-1:0];

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (pad_pu == '0 && pad_pd == '0 && pad_slew == '0 &&
                                           pad_od == '0 && pad_drv == '0 && pad_func == '0 &&
                                           !bus_rvalid && bus_rdata == '0);
        end
    end

    assert_pullup_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h80) |=> pad_pu == ($past(bus_wdata[PAD_COUNT-1:0]) & PRESENT_P));

    assert_avail_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h98) |=> bus_rdata == PRESENT);

    assert_misaligned_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

    assert_read_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pad_pu) && $stable(pad_pd) && $stable(pad_slew) &&
                     $stable(pad_od) && $stable(pad_drv) && $stable(pad_func)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (!bus_rvalid && bus_rdata == '0));

    for (genvar i = 0; i < PAD_COUNT; i++) begin : g_gap
        if (!PRESENT[i]) begin : g_missing
            assert_missing_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
                bus_wr |=> (pad_pu[i] == 1'b0 && pad_pd[i] == 1'b0 && pad_slew[i] == 1'b0 &&
                            pad_od[i] == 1'b0 && pad_drv[2*i +: 2] == 2'b00 &&
                            pad_func[i*FSEL_W +: FSEL_W] == '0));
        end
    end

endmodule

bind pad_cfg_bank pad_cfg_bank_chk #(
    .PAD_COUNT (PAD_COUNT),
    .FSEL_W    (FSEL_W),
    .AVAIL     (AVAIL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pad_func   (pad_func),
    .pad_pu     (pad_pu),
    .pad_pd     (pad_pd),
    .pad_slew   (pad_slew),
    .pad_od     (pad_od),
    .pad_drv    (pad_drv)
);

// File: tb/pad_cfg_bank_test.sv
`timescale 1ns/1ps
module pad_cfg_bank_test;

    localparam int          NP = 24;
    localparam int          FW = 3;
    localparam logic [31:0] AV = 32'hF0DF_FFF5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NP*FW-1:0]  pad_func;
    logic [NP-1:0]     pad_pu, pad_pd, pad_slew, pad_od;
    logic [2*NP-1:0]   pad_drv;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_on = 0;

    // Reference state.
    int          m_func [32];
    bit          m_pu [32];
    bit          m_pd [32];
    bit          m_slew [32];
    bit          m_od [32];
    int          m_drv [32];
    logic [31:0] e_rdata = '0;
    bit          e_rvalid = 0;

    always #2 clk = ~clk;

    pad_cfg_bank #(.PAD_COUNT(NP), .FSEL_W(FW), .AVAIL(AV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_func(pad_func), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .pad_slew(pad_slew), .pad_od(pad_od), .pad_drv(pad_drv)
    );

    function automatic bit live(int n);
        return (n < NP) && AV[n];
    endfunction

    function automatic logic [31:0] ref_read(logic [7:0] a);
        logic [31:0] w;
        w = '0;
        if (a[1:0] != 2'b00) return '0;
        if (a < 8'h80) begin
            int n;
            n = a / 4;
            if (live(n)) w = m_func[n];
            return w;
        end
        case (a)
            8'h80: for (int n = 0; n < NP; n++) w[n] = m_pu[n];
            8'h84: for (int n = 0; n < NP; n++) w[n] = m_pd[n];
            8'h88: for (int n = 0; n < NP; n++) w[n] = m_slew[n];
            8'h94: for (int n = 0; n < NP; n++) w[n] = m_od[n];
            8'h8C: for (int n = 0; n < 16 && n < NP; n++) w[2*n +: 2] = 2'(m_drv[n]);
            8'h90: for (int n = 16; n < NP; n++) w[2*(n-16) +: 2] = 2'(m_drv[n]);
            8'h98: for (int n = 0; n < 32; n++) w[n] = live(n);
            default: w = '0;
        endcase
        return w;
    endfunction

    task automatic ref_write(logic [7:0] a, logic [31:0] d);
        if (a[1:0] != 2'b00) return;
        if (a < 8'h80) begin
            int n;
            n = a / 4;
            if (live(n)) m_func[n] = d % (1 << FW);
            return;
        end
        for (int n = 0; n < 32; n++) begin
            if (live(n)) begin
                case (a)
                    8'h80: m_pu[n] = d[n];
                    8'h84: m_pd[n] = d[n];
                    8'h88: m_slew[n] = d[n];
                    8'h94: m_od[n] = d[n];
                    8'h8C: if (n < 16) m_drv[n] = d[2*n +: 2];
                    8'h90: if (n >= 16) m_drv[n] = d[2*(n-16) +: 2];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic ref_clear();
        for (int n = 0; n < 32; n++) begin
            m_func[n] = 0; m_pu[n] = 0; m_pd[n] = 0;
            m_slew[n] = 0; m_od[n] = 0; m_drv[n] = 0;
        end
        e_rdata = '0;
        e_rvalid = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_clear();
        end else begin
            if (bus_rd) begin
                e_rdata = ref_read(bus_addr);
                e_rvalid = 1;
            end else begin
                e_rdata = '0;
                e_rvalid = 0;
            end
            if (bus_wr) ref_write(bus_addr, bus_wdata);
        end
    end

    task automatic expect32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Comparison against the model on every clock.
    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            logic [31:0] a_pu, a_pd, a_sl, a_od, x_pu, x_pd, x_sl, x_od;
            logic [31:0] a_dl, a_dh, x_dl, x_dh;
            a_pu = '0; a_pd = '0; a_sl = '0; a_od = '0;
            x_pu = '0; x_pd = '0; x_sl = '0; x_od = '0;
            a_dl = '0; a_dh = '0; x_dl = '0; x_dh = '0;
            for (int n = 0; n < NP; n++) begin
                a_pu[n] = pad_pu[n]; x_pu[n] = m_pu[n];
                a_pd[n] = pad_pd[n]; x_pd[n] = m_pd[n];
                a_sl[n] = pad_slew[n]; x_sl[n] = m_slew[n];
                a_od[n] = pad_od[n]; x_od[n] = m_od[n];
                if (n < 16) begin
                    a_dl[2*n +: 2] = pad_drv[2*n +: 2]; x_dl[2*n +: 2] = 2'(m_drv[n]);
                end else begin
                    a_dh[2*(n-16) +: 2] = pad_drv[2*n +: 2]; x_dh[2*(n-16) +: 2] = 2'(m_drv[n]);
                end
                expect32("R2 func output", 32'(pad_func[n*FW +: FW]), 32'(m_func[n]));
            end
            expect32("R3 pull-up outputs", a_pu, x_pu);
            expect32("R3 pull-down outputs", a_pd, x_pd);
            expect32("R4 slew outputs", a_sl, x_sl);
            expect32("R4 open-drain outputs", a_od, x_od);
            expect32("R5 drive outputs low", a_dl, x_dl);
            expect32("R5 drive outputs high", a_dh, x_dh);
            expect32("R9 read data", bus_rdata, e_rdata);
            expect32("R11 read valid", 32'(bus_rvalid), 32'(e_rvalid));
        end
    end

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_cycle(bit wr, bit rd, logic [7:0] a, logic [31:0] d);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic rd_check(string tag, logic [7:0] a, logic [31:0] exp);
        bus_cycle(0, 1, a, '0);
        expect32(tag, bus_rdata, exp);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h1234_5678;
        ref_clear();
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        expect32("R1 pull-up in reset", 32'(pad_pu), 0);
        expect32("R1 drive in reset", 32'(pad_drv[31:0]), 0);
        expect32("R1 rvalid in reset", 32'(bus_rvalid), 0);
        rst_n = 1;
        cmp_on = 1;
        @(negedge clk);
        expect32("R1 func after reset", 32'(pad_func[31:0]), 0);

        // R6: availability bitmap, masked to 24 pads; writes ignored
        rd_check("R6 availability", 8'h98, 32'h00DF_FFF5);
        bus_cycle(1, 0, 8'h98, 32'h0000_0000);
        rd_check("R6 availability after write", 8'h98, 32'h00DF_FFF5);

        // R2: function select, truncated to 3 bits
        bus_cycle(1, 0, 8'h00, 32'h0000_000D);
        expect32("R2 pad0 func", 32'(pad_func[2:0]), 5);
        rd_check("R2 pad0 readback", 8'h00, 32'h5);
        bus_cycle(1, 0, 8'h5C, 32'h6);
        rd_check("R2 pad23 readback", 8'h5C, 32'h6);

        // R7: unavailable pad 1
        bus_cycle(1, 0, 8'h04, 32'h7);
        expect32("R7 pad1 func", 32'(pad_func[5:3]), 0);
        rd_check("R7 pad1 readback", 8'h04, 0);

        // R8: slot beyond the last pad, misaligned and high offsets
        bus_cycle(1, 0, 8'h60, 32'h7);
        rd_check("R8 slot past pads", 8'h60, 0);

        // R3: pull-up / pull-down with holes
        bus_cycle(1, 0, 8'h80, 32'hFFFF_FFFF);
        expect32("R3 pull-up masked", 32'(pad_pu), 32'h00DF_FFF5);
        bus_cycle(1, 0, 8'h84, 32'h0000_00A0);
        expect32("R3 pull-down", 32'(pad_pd), 32'h0000_00A0);

        // R4: slew and open-drain
        bus_cycle(1, 0, 8'h88, 32'h1234_5678);
        expect32("R4 slew", 32'(pad_slew), 32'h0014_5670);
        bus_cycle(1, 0, 8'h94, 32'hFFFF_0000);
        expect32("R4 open-drain", 32'(pad_od), 32'h00DF_0000);

        // R5: drive fields over two words
        bus_cycle(1, 0, 8'h8C, 32'hFFFF_FFFF);
        rd_check("R5 drive word 0", 8'h8C, 32'hFFFF_FF33);
        bus_cycle(1, 0, 8'h90, 32'hAAAA_AAAA);
        rd_check("R5 drive word 1", 8'h90, 32'h0000_A2AA);
        expect32("R5 pad16 drive pins", 32'(pad_drv[33:32]), 2);

        // R8: misaligned write leaves pull-up alone; unmapped reads
        bus_cycle(1, 0, 8'h81, 32'h0);
        expect32("R8 misaligned write", 32'(pad_pu), 32'h00DF_FFF5);
        rd_check("R8 misaligned read", 8'h81, 0);
        rd_check("R8 offset 0xFC", 8'hFC, 0);
        bus_cycle(1, 0, 8'h9C, 32'hFFFF_FFFF);
        rd_check("R8 offset 0x9C", 8'h9C, 0);

        // R9/R10: read and write together return the old word
        bus_cycle(1, 1, 8'h80, 32'h0);
        expect32("R9 read before write", bus_rdata, 32'h00DF_FFF5);
        expect32("R10 write applied", 32'(pad_pu), 0);

        // R11: back-to-back reads keep valid high, then drop
        bus_cycle(0, 1, 8'h00, 0);
        expect32("R11 first valid", 32'(bus_rvalid), 1);
        bus_cycle(0, 1, 8'h84, 0);
        expect32("R11 held valid", 32'(bus_rvalid), 1);
        expect32("R11 second word", bus_rdata, 32'h0000_00A0);
        @(negedge clk);
        expect32("R11 back to idle", 32'(bus_rvalid), 0);

        // Sweep against the model
        for (int k = 0; k < 600; k++) begin
            logic [7:0] a;
            seed = seed * 32'd1103515245 + 32'd12345;
            case (seed[31:30])
                2'd0: a = {1'b0, seed[20:16], 2'b00};
                2'd1: a = 8'h80 + {3'b000, seed[19:16], 2'b00};
                2'd2: a = {seed[23:16]};
                default: a = 8'h8C + {5'b0, seed[17:16], 2'b00};
            endcase
            bus_wr = seed[29]; bus_rd = seed[28]; bus_addr = a;
            bus_wdata = seed ^ {seed[15:0], seed[31:16]};
            @(negedge clk);
        end
        bus_wr = 0; bus_rd = 0;
        @(negedge clk);

        // R1: reset in mid-run
        cmp_on = 0;
        rst_n = 0;
        @(negedge clk);
        expect32("R1 mid-run pull-up", 32'(pad_pu), 0);
        expect32("R1 mid-run func", 32'(pad_func[31:0]), 0);
        expect32("R1 mid-run rvalid", 32'(bus_rvalid), 0);
        rst_n = 1;
        cmp_on = 1;
        @(negedge clk);
        rd_check("R1 drive after reset", 8'h8C, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule